// File: doc/BRIEF.md
# Interleaved I/Q Interpolating Front End

This block receives a single 10-bit word stream in which in-phase and quadrature samples alternate. A select line marks each word as I or Q. The block collects matching I and Q words into a pair. When the pair is complete, both halves enter two identical 2x interpolating filters in the same cycle. Each filter turns one input sample into two output samples, so a channel fed at half the clock rate produces one result on every clock. Both channel words update on the same rising edge and share one valid flag.

Each filter is a fixed 7-tap halfband FIR with weights -1, 0, 9, 16, 9, 0, -1 over a scale of 16. It runs on a zero-stuffed input, so only the non-zero products are computed. Each input sample therefore yields a copy of a stored sample followed by one computed midpoint. Samples are two's complement. Midpoints are rounded and clipped back to 10 bits. After reset the filter histories are zero, and the output is marked invalid until the histories have filled.

Top module: `iq_interp_frontend`

## Requirements
- R1: A word written (wr_en high) with sel_i high is the I half of a pair, and a word written with sel_i low is the Q half. The halves may arrive in either order. The write that completes a pair loads both filters on the same clock edge, so pairs are accepted at most once every two cycles.
- R2: If a half is written again before the other half arrives, the later word replaces the earlier one.
- R3: While rst_n is low (synchronous, active low), i_out and q_out are 0 and out_valid is 0, both filter histories clear to zero and any half-built pair is dropped.
- R4: out_valid stays low until four pairs have been accepted since reset.
- R5: Let x(p) be the newest sample accepted on a channel. One cycle after the edge that accepts pair p, the output is x(p-2). On the next cycle it is the midpoint (9*x(p-2) + 9*x(p-1) - x(p-3) - x(p) + 8) >> 4, using an arithmetic (floor) shift.
- R6: When a new pair completes every second cycle, out_valid stays high on every cycle once the histories are full.
- R7: A midpoint above 511 is output as 511, and one below -512 is output as -512.
- R8: In every cycle where out_valid is low, i_out and q_out are 0.
- R9: The I and Q channels use the same filter and the same timing, and both change on the same clock edge.
- R10: A cycle with wr_en low changes no pair state and no filter history, whatever sel_i and din carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe: din is taken on this edge |
| sel_i | input | 1 | 1 = din is an I sample, 0 = din is a Q sample |
| din | input | 10 | Interleaved two's-complement sample |
| i_out | output | 10 | Interpolated I channel sample |
| q_out | output | 10 | Interpolated Q channel sample |
| out_valid | output | 1 | Both channel outputs hold a valid sample |

## Verification
The hardest state to reach from the ports is a saturated midpoint. It needs two neighbouring full-scale samples of one sign surrounded by full-scale samples of the other sign, all inside the four-deep history window. The stimulus feeds such a pattern on both channels at once, with opposite polarity on Q, so that the upper and lower clip happen in the same cycles. Out-of-order and repeated halves, and idle cycles that carry junk on din and sel_i, are mixed in between the streaming runs. A reference model that tracks sample histories in queues predicts every output cycle.

// File: rtl/iqi_pkg.sv
// Shared types and constants for the interleaved I/Q interpolating front end.
// Assumes exactly two channels (I and Q) fed by one multiplexed bus.
package iqi_pkg;
    localparam int NUM_CH = 2;
    localparam int CH_I   = 0;
    localparam int CH_Q   = 1;

    // Which polyphase branch the filters drive onto their outputs this cycle.
    typedef enum logic [1:0] {
        EMIT_NONE   = 2'd0,
        EMIT_CENTER = 2'd1,
        EMIT_MID    = 2'd2
    } emit_e;
endpackage

// File: rtl/iqi_pair_demux.sv
// Pair assembler: holds the first half of an I/Q pair and raises pair_push
// when the write that completes the pair arrives. Assumes at most one
// written word per cycle, so a push can never occur on consecutive cycles.
module iqi_pair_demux #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         sel_i,
    input  logic [W-1:0] din,
    output logic         pair_push,
    output logic [W-1:0] samp_i,
    output logic [W-1:0] samp_q
);
    logic [W-1:0] hold_i, hold_q;
    logic         have_i, have_q;

    // Completing write: the opposite half is already waiting.
    always_comb begin
        pair_push = wr_en && (sel_i ? have_q : have_i);
        samp_i    = sel_i ? din : hold_i;
        samp_q    = sel_i ? hold_q : din;
    end

    // Capture a lone half, or release both halves when a pair completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_i <= '0;
            hold_q <= '0;
            have_i <= 1'b0;
            have_q <= 1'b0;
        end else if (pair_push) begin
            have_i <= 1'b0;
            have_q <= 1'b0;
        end else if (wr_en) begin
            if (sel_i) begin
                hold_i <= din;
                have_i <= 1'b1;
            end else begin
                hold_q <= din;
                have_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/iqi_phase_ctrl.sv
// Shared phase controller: after each accepted pair it drives the centre
// branch on the next edge and the midpoint branch on the edge after.
// Output is gated until FILL_PAIRS pairs have entered the histories.
// Assumes pushes are at least two cycles apart.
module iqi_phase_ctrl
    import iqi_pkg::*;
#(
    parameter int FILL_PAIRS = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  push,
    output emit_e emit,
    output logic  filled,
    output logic  out_valid
);
    localparam int CW = $clog2(FILL_PAIRS + 1);

    logic          push_d;
    logic          mid_due;
    logic [CW-1:0] fill_cnt;

    // History is full once FILL_PAIRS pairs have been accepted.
    always_comb filled = (fill_cnt == CW'(FILL_PAIRS));

    // Choose the branch to present this edge.
    always_comb begin
        if (push_d && filled)       emit = EMIT_CENTER;
        else if (mid_due && filled) emit = EMIT_MID;
        else                        emit = EMIT_NONE;
    end

    // Phase sequencing, fill counting and the registered valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            push_d    <= 1'b0;
            mid_due   <= 1'b0;
            fill_cnt  <= '0;
            out_valid <= 1'b0;
        end else begin
            push_d    <= push;
            mid_due   <= push_d;
            out_valid <= (emit != EMIT_NONE);
            if (push && !filled) fill_cnt <= fill_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/iqi_halfband.sv
// One channel of the 2x halfband interpolator (taps -1,0,9,16,9,0,-1 / 16).
// Keeps the last four input samples. The centre branch returns the
// third-newest sample; the midpoint branch computes the even-tap sum, then
// rounds and clips it. The output is zero when no branch is selected.
module iqi_halfband
    import iqi_pkg::*;
#(
    parameter int W    = 10,
    parameter int FRAC = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] samp,
    input  emit_e        emit,
    output logic [W-1:0] y
);
    localparam int DEPTH = 4;
    localparam int SW    = W + FRAC + 2;
    localparam logic signed [SW-1:0] RND  = SW'(1 << (FRAC - 1));
    localparam logic signed [SW-1:0] MAXV = SW'((1 << (W - 1)) - 1);
    localparam logic signed [SW-1:0] MINV = ~MAXV;

    logic [W-1:0]          tap [DEPTH];
    logic signed [SW-1:0]  e0, e1, e2, e3, pair_sum, acc, rnd;
    logic [W-1:0]          mid_sat;

    // Sign extension of a stored sample to the accumulator width.
    function automatic logic signed [SW-1:0] sext(input logic [W-1:0] v);
        return $signed({{(SW - W){v[W-1]}}, v});
    endfunction

    // Delay line shifts only when a pair is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) tap[k] <= '0;
        end else if (push) begin
            tap[0] <= samp;
            for (int k = 1; k < DEPTH; k++) tap[k] <= tap[k-1];
        end
    end

    // Midpoint branch: 9*(t1+t2) - t0 - t3, rounded, then clipped.
    always_comb begin
        e0       = sext(tap[0]);
        e1       = sext(tap[1]);
        e2       = sext(tap[2]);
        e3       = sext(tap[3]);
        pair_sum = e1 + e2;
        acc      = (pair_sum <<< 3) + pair_sum - e0 - e3;
        rnd      = (acc + RND) >>> FRAC;
        if (rnd > MAXV)      mid_sat = MAXV[W-1:0];
        else if (rnd < MINV) mid_sat = MINV[W-1:0];
        else                 mid_sat = rnd[W-1:0];
    end

    // Output register driven by the shared phase select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y <= '0;
        end else begin
            case (emit)
                EMIT_CENTER: y <= tap[2];
                EMIT_MID:    y <= mid_sat;
                default:     y <= '0;
            endcase
        end
    end
endmodule

// File: rtl/iq_interp_frontend.sv
// Top level: splits the interleaved bus into I/Q pairs and runs two matched
// halfband interpolators in lockstep under one phase controller, so both
// outputs change on the same edge and share one valid flag.
module iq_interp_frontend
    import iqi_pkg::*;
#(
    parameter int W          = 10,
    parameter int FRAC       = 4,
    parameter int FILL_PAIRS = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         sel_i,
    input  logic [W-1:0] din,
    output logic [W-1:0] i_out,
    output logic [W-1:0] q_out,
    output logic         out_valid
);
    logic         pair_push;
    logic         filled;
    emit_e        emit;
    logic [W-1:0] ch_in  [NUM_CH];
    logic [W-1:0] ch_out [NUM_CH];

    iqi_pair_demux #(.W(W)) u_demux (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .sel_i     (sel_i),
        .din       (din),
        .pair_push (pair_push),
        .samp_i    (ch_in[CH_I]),
        .samp_q    (ch_in[CH_Q])
    );

    iqi_phase_ctrl #(.FILL_PAIRS(FILL_PAIRS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (pair_push),
        .emit      (emit),
        .filled    (filled),
        .out_valid (out_valid)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        iqi_halfband #(.W(W), .FRAC(FRAC)) u_hb (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (pair_push),
            .samp  (ch_in[c]),
            .emit  (emit),
            .y     (ch_out[c])
        );
    end

    // Channel outputs to ports.
    always_comb begin
        i_out = ch_out[CH_I];
        q_out = ch_out[CH_Q];
    end
endmodule

// File: rtl/iqi_checker.sv
// Property checker for iq_interp_frontend, attached by bind below.
// Observes the pair-complete strobe and fill status beside the ports.
module iqi_checker #(
    parameter int W = 10
) (
    input logic         clk,
    input logic         rst_n,
    input logic         pair_push,
    input logic         filled,
    input logic         out_valid,
    input logic [W-1:0] i_out,
    input logic [W-1:0] q_out
);
    // R1: a completed pair is never followed at once by another.
    assert_pair_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pair_push |=> !pair_push);

    // R4: no valid output while the histories are still filling.
    assert_fill_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !filled |=> !out_valid);

    // R5: every valid sample traces back to a pair two or three cycles earlier.
    assert_valid_origin_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(pair_push, 2) || $past(pair_push, 3)));

    // R6: a centre sample is always followed by its midpoint.
    assert_mid_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(pair_push, 2)) |=> out_valid);

    // R8: outputs are zero when not valid.
    assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (i_out == '0 && q_out == '0));
endmodule

bind iq_interp_frontend iqi_checker #(.W(W)) u_iqi_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .pair_push (pair_push),
    .filled    (filled),
    .out_valid (out_valid),
    .i_out     (i_out),
    .q_out     (q_out)
);

// File: tb/iq_interp_frontend_tb_top.sv
// Bench: behavioural queue-based reference model, compared on every clock.
module iq_interp_frontend_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       sel_i = 1'b0;
    logic [9:0] din = '0;
    logic [9:0] i_out, q_out;
    logic       out_valid;

    int    n_checks = 0;
    int    n_errors = 0;
    string cur_req = "R3";

    always #2.5 clk = ~clk;

    iq_interp_frontend dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel_i(sel_i), .din(din),
        .i_out(i_out), .q_out(q_out), .out_valid(out_valid)
    );

    // Reference model state.
    int hist_i[$];
    int hist_q[$];
    bit wait_i, wait_q;
    int held_i, held_q;
    int phase_next;
    int pairs_in;
    int exp_i, exp_q;
    bit exp_v;

    function automatic int clip(input int v);
        if (v > 511) return 511;
        if (v < -512) return -512;
        return v;
    endfunction

    function automatic int midpoint(input int h[$]);
        int n = h.size();
        int s = 9 * h[n-2] + 9 * h[n-3] - h[n-1] - h[n-4] + 8;
        return clip(s >>> 4);
    endfunction

    function automatic int to_int(input logic [9:0] v);
        return int'($signed(v));
    endfunction

    task automatic accept(input int vi, input int vq);
        hist_i.push_back(vi);
        hist_q.push_back(vq);
        if (hist_i.size() > 8) begin
            void'(hist_i.pop_front());
            void'(hist_q.pop_front());
        end
        pairs_in++;
        phase_next = 1;
        wait_i = 0;
        wait_q = 0;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            hist_i = '{0, 0, 0, 0};
            hist_q = '{0, 0, 0, 0};
            wait_i = 0; wait_q = 0; held_i = 0; held_q = 0;
            phase_next = 0; pairs_in = 0;
            exp_i = 0; exp_q = 0; exp_v = 0;
        end else begin
            if (phase_next == 1 && pairs_in >= 4) begin
                exp_v = 1;
                exp_i = hist_i[hist_i.size()-3];
                exp_q = hist_q[hist_q.size()-3];
            end else if (phase_next == 2 && pairs_in >= 4) begin
                exp_v = 1;
                exp_i = midpoint(hist_i);
                exp_q = midpoint(hist_q);
            end else begin
                exp_v = 0; exp_i = 0; exp_q = 0;
            end
            phase_next = (phase_next == 1) ? 2 : 0;
            if (wr_en) begin
                if (sel_i) begin
                    if (wait_q) accept(to_int(din), held_q);
                    else begin held_i = to_int(din); wait_i = 1; end
                end else begin
                    if (wait_i) accept(held_i, to_int(din));
                    else begin held_q = to_int(din); wait_q = 1; end
                end
            end
        end
    end

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        n_checks++;
        if (out_valid !== exp_v || to_int(i_out) != exp_i || to_int(q_out) != exp_q
            || $isunknown({i_out, q_out, out_valid})) begin
            n_errors++;
            $display("FAIL %s t=%0t: actual v=%0d i=%0d q=%0d expected v=%0d i=%0d q=%0d",
                     cur_req, $time, out_valid, to_int(i_out), to_int(q_out),
                     exp_v, exp_i, exp_q);
        end
    end

    task automatic put(input bit s, input int v);
        @(negedge clk);
        wr_en = 1'b1; sel_i = s; din = v[9:0];
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            wr_en = 1'b0; sel_i = k[0]; din = 10'(k * 97 + 13);
        end
    endtask

    task automatic put_pair(input int vi, input int vq, input bit q_first);
        if (q_first) begin put(1'b0, vq); put(1'b1, vi); end
        else begin put(1'b1, vi); put(1'b0, vq); end
    endtask

    task automatic do_reset(input int n);
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0;
        repeat (n) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        int run;
        cur_req = "R3";
        do_reset(3);
        // R1/R4/R5/R6/R9: back-to-back pairs, I first, distinct I and Q data.
        cur_req = "R1/R4/R5/R6/R9";
        for (int k = 0; k < 10; k++) put_pair(k * 37 - 150, 200 - k * 23, 1'b0);
        // R6: explicit run of valid cycles once streaming is full.
        cur_req = "R6";
        run = 0;
        for (int k = 0; k < 6; k++) begin
            put_pair(k * 11, -k * 13, 1'b0);
            if (out_valid) run++;
            @(posedge clk);
            #1;
            if (out_valid) run++;
        end
        n_checks++;
        if (run != 12) begin
            n_errors++;
            $display("FAIL R6: actual valid cycles %0d expected 12", run);
        end
        // R1: Q half first.
        cur_req = "R1";
        for (int k = 0; k < 6; k++) put_pair(-300 + k * 90, 100 + k * 7, 1'b1);
        // R10/R8: idle gaps with junk on the bus.
        cur_req = "R10/R8";
        idle(7);
        put_pair(5, -5, 1'b0);
        idle(5);
        put_pair(-77, 66, 1'b1);
        idle(4);
        // R2: rewrite halves before completion.
        cur_req = "R2";
        put(1'b1, 123); put(1'b1, -45); put(1'b0, 310);
        put(1'b0, 7); put(1'b0, -260); put(1'b1, 99);
        for (int k = 0; k < 3; k++) put_pair(k * 50, -k * 40, 1'b0);
        idle(4);
        // R7: saturating midpoints, upper on I and lower on Q.
        cur_req = "R7";
        for (int k = 0; k < 12; k++) begin
            int a = (k % 4 == 1 || k % 4 == 2) ? 511 : -512;
            int b = (k % 4 == 1 || k % 4 == 2) ? -512 : 511;
            put_pair(a, b, k[0]);
        end
        idle(4);
        // R3: reset in the middle of a stream, with a half pair pending.
        cur_req = "R3";
        put_pair(40, 41, 1'b0);
        put(1'b1, 300);
        do_reset(2);
        cur_req = "R4/R3";
        for (int k = 0; k < 6; k++) put_pair(k * 3 + 1, -k * 3 - 2, 1'b0);
        idle(5);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule